// File: doc/BRIEF.md
# Nibble Bus Clock/Calendar Register Interface

This block is the host-side access logic for a clock/calendar register file. A single 4-bit bus carries both address and data. Two chip selects must both be high before the interface reacts to anything. A level-sensitive address strobe loads the register address from the bus. Level-sensitive write and read strobes then move data between the bus and the selected digit. The block drives the bus as a data value together with an output enable, which stands in for an open-drain driver.

Thirteen addresses select time and date digits, from seconds units up to year tens. For each digit the block keeps only the bits that the digit implements. Address 13 does not select a digit. Writing to it raises a reset request toward the prescaler and the busy logic. Addresses 14 and 15 return four live reference signals instead of register data.

While the counters are running, a busy indication from the counting logic limits access to the digits. After busy falls, digit reads and writes are still served for a short grace window. After that window they are held off until busy returns high. When a stop input holds the counters, this limit does not apply.

Top module: `nibble_bus_if`

## Requirements
- R1: The interface is selected only when `cs_a` and `cs_b` are both high. While it is not selected, `astb`, `wstb`, `rstb`, `stop_in` and `test_in` have no effect: the address does not change, no digit is written, `bus_oe` stays low and `cnt_hold` keeps its value.
- R2: The address latch follows `bus_in` in every cycle that the interface is selected with `astb` high, and that address applies in the same cycle. When `astb` is low, the latch keeps its last value.
- R3: Address `k`, for k = 0 to 12, selects digit k. Digit 0 is seconds units, 1 is seconds tens, 2 is minutes units, 3 is minutes tens, 4 is hours units, 5 is hours tens, 6 is weekday, 7 is day units, 8 is day tens, 9 is month units, 10 is month tens, 11 is year units and 12 is year tens. The write enable `dig_wen[k]` is the only enable bit that can be set for address k.
- R4: Writing is level-sensitive. For every clock cycle that the interface is selected and `wstb` is high, `dig_wen` has the bit of the addressed digit set in the following cycle, and `dig_wdata` holds the masked bus value.
- R5: Each digit implements only some bits. The bit masks are: digits 1, 3 and 6 keep bits [2:0]; digit 10 keeps bit 0; digits 0, 2, 4, 5, 7, 8, 9, 11 and 12 keep all four bits. Bits outside the mask are dropped on a write and read back as 0.
- R6: For hours tens (address 5), bit 3 selects 24-hour mode and bit 2 marks PM. A write with bit 3 = 1 stores bit 2 as 0.
- R7: A selected write to address 13 raises `pres_rst` in the following cycle for as long as `wstb` stays high, and it writes no digit. A read of address 13 returns 0.
- R8: A selected read of address 14 or 15 drives `ref_sig[3:0]` onto `bus_out` bit for bit.
- R9: `bus_oe` is high exactly one cycle after a cycle in which the interface was selected, `rstb` was high, `wstb` was low and the access was not held off (see R10). `bus_out` is 0 whenever `bus_oe` is low.
- R10: While `cnt_hold` is low and `busy_n` is low, digit reads and writes are served for the first GRACE_CYC cycles after busy falls and are then suppressed until `busy_n` returns high. While `cnt_hold` is high, busy has no effect. Address 13 and addresses 14 and 15 are never suppressed.
- R11: `cnt_hold` takes the value of `stop_in` one cycle after any selected cycle. `test_pulse` is high one cycle after a selected cycle in which `test_in` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_a | input | 1 | Chip select, first of two |
| cs_b | input | 1 | Chip select, second of two |
| astb | input | 1 | Address strobe, level-sensitive |
| wstb | input | 1 | Write strobe, level-sensitive |
| rstb | input | 1 | Read strobe, level-sensitive |
| stop_in | input | 1 | Request to hold the digit counters |
| test_in | input | 1 | Test count request |
| bus_in | input | 4 | Value sensed on the nibble bus |
| bus_out | output | 4 | Value driven onto the nibble bus |
| bus_oe | output | 1 | Bus drive enable |
| busy_n | input | 1 | Count-busy indication, low while the counters update |
| ref_sig | input | 4 | Reference signals returned at addresses 14 and 15 |
| rd_addr | output | 4 | Current address presented to the register file |
| rd_data | input | 4 | Register file contents at `rd_addr` |
| dig_wen | output | 13 | One-hot digit write enables |
| dig_wdata | output | 4 | Masked write data |
| pres_rst | output | 1 | Reset request to the prescaler and busy logic |
| cnt_hold | output | 1 | Latched counter-hold request |
| test_pulse | output | 1 | Gated test count request |

## Verification
The bench sweeps every data value through every digit address and then reads each value back. A wrong mask would leave a stray bit in place or clear a real one. The hours-tens rule is covered by the same sweep: if the PM bit is not cleared under 24-hour mode, values 12 and up at address 5 read back with bit 2 still set. A write of a distinct pattern to every digit catches a decoder that writes to two digits at once.

The bench counts the cycles of the busy grace window and checks that an access is still served on the last allowed cycle and blocked on the next. A design whose window is off by one fails at that boundary. The bench also checks that a write issued during the hold-off leaves the digit unchanged. Further checks cover a deselected interface that still moves the address latch, and a read that drives the bus while the write strobe is high.

// File: rtl/nbi_pkg.sv
package nbi_pkg;

    localparam int NIB_W   = 4;
    localparam int NUM_DIG = 13;

    localparam logic [NIB_W-1:0] ADR_PRST = 4'd13;
    localparam logic [NIB_W-1:0] ADR_REF  = 4'd14;
    localparam logic [NIB_W-1:0] ADR_H10  = 4'd5;

    localparam int HR24_BIT = 3;
    localparam int PM_BIT   = 2;

    // Implemented bits per digit address; non-digit codes keep nothing
    function automatic logic [NIB_W-1:0] dig_mask(input logic [NIB_W-1:0] adr);
        logic [NIB_W-1:0] m;
        case (adr)
            4'd1, 4'd3, 4'd6:                      m = 4'b0111;
            4'd10:                                 m = 4'b0001;
            4'd0, 4'd2, 4'd4, 4'd5, 4'd7, 4'd8,
            4'd9, 4'd11, 4'd12:                    m = 4'b1111;
            default:                               m = 4'b0000;
        endcase
        return m;
    endfunction

    typedef struct packed {
        logic [NUM_DIG-1:0] wen;
        logic [NIB_W-1:0]   wdata;
        logic [NIB_W-1:0]   dout;
        logic               oe;
        logic               prst;
        logic               hold;
        logic               tst;
    } nbi_state_t;

endpackage

// File: rtl/nbi_addr_latch.sv
module nbi_addr_latch
    import nbi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [NIB_W-1:0]   bus_in,
    output logic [NIB_W-1:0]   addr_eff,
    output logic [NUM_DIG-1:0] dig_hit,
    output logic               hit_prst,
    output logic               hit_ref
);

    logic [NIB_W-1:0] addr_d, addr_q;

    // Transparent while loading, holding otherwise
    always_comb begin
        addr_d = load ? bus_in : addr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_eff = addr_d;

    generate
        for (genvar g = 0; g < NUM_DIG; g++) begin : g_dec
            assign dig_hit[g] = (addr_eff == NIB_W'(g));
        end
    endgenerate

    assign hit_prst = (addr_eff == ADR_PRST);
    assign hit_ref  = (addr_eff >= ADR_REF);

endmodule

// File: rtl/nbi_busy_guard.sv
module nbi_busy_guard #(
    parameter int GRACE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic busy_n,
    output logic inhibit
);

    localparam int            CW    = $clog2(GRACE_CYC + 2);
    localparam logic [CW-1:0] LIMIT = CW'(GRACE_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (busy_n)              cnt_d = '0;
        else if (cnt_q == LIMIT) cnt_d = cnt_q;
        else                     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Grace window used up while counting runs and busy is still low
    assign inhibit = run & ~busy_n & (cnt_q == LIMIT);

endmodule

// File: rtl/nbi_data_path.sv
module nbi_data_path
    import nbi_pkg::*;
(
    input  logic [NIB_W-1:0] addr_eff,
    input  logic [NIB_W-1:0] bus_in,
    input  logic [NIB_W-1:0] rd_data,
    input  logic [NIB_W-1:0] ref_sig,
    input  logic             hit_ref,
    output logic [NIB_W-1:0] wdata_m,
    output logic [NIB_W-1:0] rdata_m
);

    logic [NIB_W-1:0] mask;

    always_comb begin
        mask    = dig_mask(addr_eff);
        wdata_m = bus_in & mask;
        // 24-hour mode forces the PM flag clear
        if (addr_eff == ADR_H10 && wdata_m[HR24_BIT])
            wdata_m[PM_BIT] = 1'b0;
        rdata_m = hit_ref ? ref_sig : (rd_data & mask);
    end

endmodule

// File: rtl/nibble_bus_if.sv
module nibble_bus_if
    import nbi_pkg::*;
#(
    parameter int GRACE_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_a,
    input  logic               cs_b,
    input  logic               astb,
    input  logic               wstb,
    input  logic               rstb,
    input  logic               stop_in,
    input  logic               test_in,
    input  logic [NIB_W-1:0]   bus_in,
    output logic [NIB_W-1:0]   bus_out,
    output logic               bus_oe,
    input  logic               busy_n,
    input  logic [NIB_W-1:0]   ref_sig,
    output logic [NIB_W-1:0]   rd_addr,
    input  logic [NIB_W-1:0]   rd_data,
    output logic [NUM_DIG-1:0] dig_wen,
    output logic [NIB_W-1:0]   dig_wdata,
    output logic               pres_rst,
    output logic               cnt_hold,
    output logic               test_pulse
);

    nbi_state_t st_d, st_q;

    logic               sel;
    logic [NIB_W-1:0]   addr_eff;
    logic [NUM_DIG-1:0] dig_hit;
    logic               hit_prst, hit_ref;
    logic               inhibit;
    logic [NIB_W-1:0]   wdata_m, rdata_m;
    logic               rd_ok;

    assign sel = cs_a & cs_b;

    nbi_addr_latch i_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sel & astb),
        .bus_in   (bus_in),
        .addr_eff (addr_eff),
        .dig_hit  (dig_hit),
        .hit_prst (hit_prst),
        .hit_ref  (hit_ref)
    );

    nbi_busy_guard #(.GRACE_CYC(GRACE_CYC)) i_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (~st_q.hold),
        .busy_n  (busy_n),
        .inhibit (inhibit)
    );

    nbi_data_path i_dp (
        .addr_eff (addr_eff),
        .bus_in   (bus_in),
        .rd_data  (rd_data),
        .ref_sig  (ref_sig),
        .hit_ref  (hit_ref),
        .wdata_m  (wdata_m),
        .rdata_m  (rdata_m)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wen   = (sel & wstb & ~inhibit) ? dig_hit : '0;
        st_d.wdata = wdata_m;
        st_d.prst  = sel & wstb & hit_prst;
        // Digit reads obey the busy guard; special codes do not
        rd_ok      = sel & rstb & ~wstb & ~(inhibit & ~hit_ref & ~hit_prst);
        st_d.oe    = rd_ok;
        st_d.dout  = rd_ok ? rdata_m : '0;
        if (sel) st_d.hold = stop_in;
        st_d.tst   = sel & test_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_addr    = addr_eff;
    assign bus_out    = st_q.dout;
    assign bus_oe     = st_q.oe;
    assign dig_wen    = st_q.wen;
    assign dig_wdata  = st_q.wdata;
    assign pres_rst   = st_q.prst;
    assign cnt_hold   = st_q.hold;
    assign test_pulse = st_q.tst;

endmodule

// File: rtl/nbi_checker.sv
module nbi_checker
    import nbi_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cs_a,
    input logic               cs_b,
    input logic               astb,
    input logic               wstb,
    input logic               rstb,
    input logic [NIB_W-1:0]   bus_out,
    input logic               bus_oe,
    input logic [NIB_W-1:0]   rd_addr,
    input logic [NUM_DIG-1:0] dig_wen,
    input logic [NIB_W-1:0]   dig_wdata,
    input logic               pres_rst
);

    // R3
    wen_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_wen));

    // R1
    wen_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_wen != '0) |-> $past(cs_a && cs_b && wstb));

    // R9
    oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> $past(cs_a && cs_b && rstb && !wstb));

    // R9
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));

    // R7
    prst_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pres_rst |-> (dig_wen == '0));

    // R6
    h24_pm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dig_wen[ADR_H10] |-> !(dig_wdata[HR24_BIT] && dig_wdata[PM_BIT]));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cs_a && cs_b && astb) && !$past(cs_a && cs_b && astb)) |-> $stable(rd_addr));

endmodule

bind nibble_bus_if nbi_checker i_nbi_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_a      (cs_a),
    .cs_b      (cs_b),
    .astb      (astb),
    .wstb      (wstb),
    .rstb      (rstb),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .rd_addr   (rd_addr),
    .dig_wen   (dig_wen),
    .dig_wdata (dig_wdata),
    .pres_rst  (pres_rst)
);

// File: tb/test_nibble_bus_if.sv
`timescale 1ns/1ps
module test_nibble_bus_if;

    localparam int GRACE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_a = 1'b1, cs_b = 1'b1;
    logic        astb = 1'b0, wstb = 1'b0, rstb = 1'b0;
    logic        stop_in = 1'b0, test_in = 1'b0;
    logic [3:0]  bus_in = '0;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic        busy_n = 1'b1;
    logic [3:0]  ref_sig = '0;
    logic [3:0]  rd_addr;
    logic [3:0]  rd_data;
    logic [12:0] dig_wen;
    logic [3:0]  dig_wdata;
    logic        pres_rst, cnt_hold, test_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] regs [13];

    always #5 clk = ~clk;

    nibble_bus_if #(.GRACE_CYC(GRACE)) i_nibble_bus_if (.*);

    // Stub register file
    always @(posedge clk) begin
        for (int i = 0; i < 13; i++) begin
            if (!rst_n)          regs[i] <= '0;
            else if (dig_wen[i]) regs[i] <= dig_wdata;
        end
    end
    assign rd_data = (rd_addr < 4'd13) ? regs[rd_addr] : 4'hF;

    function automatic logic [3:0] exp_val(input int a, input logic [3:0] d);
        logic [3:0] m;
        case (a)
            1, 3, 6: m = 4'h7;
            10:      m = 4'h1;
            13, 14, 15: m = 4'h0;
            default: m = 4'hF;
        endcase
        m = m & d;
        if (a == 5 && m[3]) m[2] = 1'b0;
        return m;
    endfunction

    task automatic chk(input string tag, input logic [12:0] act, input logic [12:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_addr(input logic [3:0] a);
        @(negedge clk); bus_in = a; astb = 1'b1;
        @(negedge clk); astb = 1'b0;
    endtask

    task automatic wr_dig(input logic [3:0] d);
        bus_in = d; wstb = 1'b1;
        @(negedge clk); wstb = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_dig(output logic [3:0] d, output logic oe);
        rstb = 1'b1;
        @(negedge clk); d = bus_out; oe = bus_oe; rstb = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [3:0] d;
        logic oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset R9 oe", 13'(bus_oe), 13'd0);
        chk("reset R4 wen", dig_wen, 13'd0);
        chk("reset R7 prst", 13'(pres_rst), 13'd0);

        // R5 R6: full sweep of data through every digit
        for (int a = 0; a < 13; a++) begin
            for (int v = 0; v < 16; v++) begin
                set_addr(4'(a));
                wr_dig(4'(v));
                rd_dig(d, oe);
                chk($sformatf("R5 mask a=%0d v=%0d", a, v), 13'(d), 13'(exp_val(a, 4'(v))));
                if (v == 15) chk("R9 oe on read", 13'(oe), 13'd1);
            end
        end

        // R3: distinct pattern per digit, read all back
        for (int a = 0; a < 13; a++) begin set_addr(4'(a)); wr_dig(4'(a) ^ 4'h9); end
        for (int a = 0; a < 13; a++) begin
            set_addr(4'(a)); rd_dig(d, oe);
            chk($sformatf("R3 map a=%0d", a), 13'(d), 13'(exp_val(a, 4'(a) ^ 4'h9)));
        end

        // R4: write enable bit and one-cycle latency
        set_addr(4'd7);
        bus_in = 4'h3; wstb = 1'b1;
        @(negedge clk);
        chk("R4 wen bit", dig_wen, 13'h1 << 7);
        @(negedge clk);
        chk("R4 wen level", dig_wen, 13'h1 << 7);
        wstb = 1'b0;
        @(negedge clk);
        chk("R4 wen drop", dig_wen, 13'd0);

        // R2: hold with strobe low, transparent with strobe high
        set_addr(4'd3);
        bus_in = 4'd8;
        rd_dig(d, oe);
        chk("R2 hold", 13'(d), 13'(exp_val(3, 4'd3 ^ 4'h9)));
        @(negedge clk); bus_in = 4'd8; astb = 1'b1; rstb = 1'b1;
        @(negedge clk); d = bus_out; astb = 1'b0; rstb = 1'b0;
        chk("R2 transparent", 13'(d), 13'(exp_val(8, 4'd8 ^ 4'h9)));

        // R1: deselected address, write, read and stop ignored
        set_addr(4'd2);
        stop_in = 1'b1; @(negedge clk); stop_in = 1'b0;
        chk("R11 hold set", 13'(cnt_hold), 13'd1);
        cs_b = 1'b0;
        set_addr(4'd9);
        wr_dig(4'h0);
        stop_in = 1'b0;
        rd_dig(d, oe);
        chk("R1 no oe deselected", 13'(oe), 13'd0);
        chk("R1 stop ignored", 13'(cnt_hold), 13'd1);
        test_in = 1'b1; @(negedge clk);
        chk("R1 test ignored", 13'(test_pulse), 13'd0);
        cs_b = 1'b1; @(negedge clk);
        chk("R11 test pulse", 13'(test_pulse), 13'd1);
        test_in = 1'b0;
        chk("R11 hold follows", 13'(cnt_hold), 13'd0);
        rd_dig(d, oe);
        chk("R1 addr/data kept", 13'(d), 13'(exp_val(2, 4'd2 ^ 4'h9)));

        // R7: prescaler reset code
        set_addr(4'd13);
        bus_in = 4'hF; wstb = 1'b1;
        @(negedge clk);
        chk("R7 prst high", 13'(pres_rst), 13'd1);
        chk("R7 no digit write", dig_wen, 13'd0);
        wstb = 1'b0;
        @(negedge clk);
        chk("R7 prst low", 13'(pres_rst), 13'd0);
        rd_dig(d, oe);
        chk("R7 read zero", 13'(d), 13'd0);

        // R8: reference readout at 14 and 15
        ref_sig = 4'b1010;
        set_addr(4'd14); rd_dig(d, oe);
        chk("R8 ref 14", 13'(d), 13'(4'b1010));
        ref_sig = 4'b0101;
        set_addr(4'd15); rd_dig(d, oe);
        chk("R8 ref 15", 13'(d), 13'(4'b0101));

        // R9: read with write strobe high is not driven
        @(negedge clk); rstb = 1'b1; wstb = 1'b1;
        @(negedge clk); oe = bus_oe; rstb = 1'b0; wstb = 1'b0;
        chk("R9 no contention", 13'(oe), 13'd0);

        // R10: grace window then suppression while counting runs
        set_addr(4'd0); wr_dig(4'h6);
        @(negedge clk); rstb = 1'b1; busy_n = 1'b0;
        for (int j = 1; j <= GRACE + 2; j++) begin
            @(negedge clk);
            chk($sformatf("R10 grace j=%0d", j), 13'(bus_oe), 13'(j <= GRACE));
        end
        busy_n = 1'b1;
        @(negedge clk);
        chk("R10 resume", 13'(bus_oe), 13'd1);
        rstb = 1'b0;
        busy_n = 1'b0;
        repeat (GRACE + 1) @(negedge clk);
        wr_dig(4'h2);
        busy_n = 1'b1;
        rd_dig(d, oe);
        chk("R10 write suppressed", 13'(d), 13'h6);

        // R10: hold high disables the guard
        stop_in = 1'b1; @(negedge clk);
        busy_n = 1'b0;
        repeat (GRACE + 3) @(negedge clk);
        rd_dig(d, oe);
        chk("R10 hold ignores busy", 13'(oe), 13'd1);
        busy_n = 1'b1; stop_in = 1'b0;

        summary();
    end

endmodule